// File: doc/BRIEF.md
# Rectangular Block-Transfer Size and Start Sequencer

This block is the sequencing core of a two-dimensional block-transfer engine. Software programs a rectangle size, a destination pointer, a signed line modulo and an 8-bit logic function. The size can be given in two ways. One is a compact packed word that holds both height and width. The other is a pair of wide registers, vertical first and horizontal second. A write of the packed word, or of the horizontal register, starts the transfer.

While the transfer runs, the block steps through the rectangle one 16-bit word per clock. It raises a read strobe for every word and a write strobe for every word it stores. The destination address advances by one word each step and takes the modulo at every line end. Each output word is an arbitrary three-input Boolean function of the A, B and C source words present in that cycle, applied bit by bit. A control bit can suppress all destination stores while reads and address stepping continue. The block raises busy for the whole transfer and gives a one-cycle done pulse at the end.

Top module: `blit_extent_seq`

## Requirements
- R1: Register writes use `wr_sel` codes: 0 packed size, 1 vertical size, 2 horizontal size, 3 control word (all 16 bits), 4 control low-byte alias, 5 control-1, 6 pointer high (bits 4..0 give address bits 20..16), 7 pointer low (bits 15..1 give address bits 15..1, bit 0 ignored), 8 signed byte modulo (bit 0 ignored). A packed-size write (height in bits 15..6, width in words in bits 5..0) starts a transfer of width × height words.
- R2: A vertical-size write (height in bits 14..0) starts nothing. The next horizontal-size write (width in words in bits 10..0) starts a transfer that uses the stored height. Busy is high at the first clock edge after the starting write.
- R3: A zero size field means the largest count: 64 words or 1024 lines for the packed word, and 2048 words or 32768 lines for the pair.
- R4: Output data bit k equals bit {A[k],B[k],C[k]} of the control word's low byte, with A as the most significant index bit.
- R5: When control-1 bit 7 is set, each word still raises the read strobe and steps the address, but the write strobe never rises.
- R6: A low-byte alias write replaces only the logic function and leaves control bits 15..8 (output `ctl_hi`) unchanged. A full control write sets both bytes.
- R7: The first word goes to the programmed pointer. Each later word goes 2 bytes above the previous one, plus the signed modulo after every line end, including the last line. The pointer keeps its final value for the next transfer.
- R8: Busy stays high for exactly width × height cycles. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R9: While busy, every register write is ignored: size, pointer, modulo and control.
- R10: After reset, busy, done, both strobes and `ctl_hi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 16 | Register write data |
| src_a | input | 16 | Source A word for the current step |
| src_b | input | 16 | Source B word for the current step |
| src_c | input | 16 | Source C word for the current step |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_stb | output | 1 | Source word consumed this cycle |
| wr_stb | output | 1 | Destination word stored this cycle |
| wr_addr | output | 21 | Destination byte address, bit 0 zero |
| dst_data | output | 16 | Destination data word |
| ctl_hi | output | 8 | Upper byte of the control word |

## Verification
A word counter or line counter that starts wrong or reloads wrong changes the number of strobes. The error is visible only when busy falls, so the bench compares exact read, write and busy counts for each rectangle, including every zero-means-maximum case. A wrong address step shows up in the last store address after one transfer. When stores are suppressed, the same fault shows up in the first address of the following transfer. A corrupted function byte, or a write that slips through while busy, alters `dst_data` or `ctl_hi` in the very next word or idle cycle.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
   localparam int SEL_W = 4;
   localparam logic [SEL_W-1:0] SEL_PACKED = 4'd0;
   localparam logic [SEL_W-1:0] SEL_VSIZE  = 4'd1;
   localparam logic [SEL_W-1:0] SEL_HSIZE  = 4'd2;
   localparam logic [SEL_W-1:0] SEL_CTL0   = 4'd3;
   localparam logic [SEL_W-1:0] SEL_CTL0LO = 4'd4;
   localparam logic [SEL_W-1:0] SEL_CTL1   = 4'd5;
   localparam logic [SEL_W-1:0] SEL_PTRHI  = 4'd6;
   localparam logic [SEL_W-1:0] SEL_PTRLO  = 4'd7;
   localparam logic [SEL_W-1:0] SEL_DMOD   = 4'd8;
   localparam int STORE_OFF_BIT = 7;
endpackage

// File: rtl/bxs_regs.sv
module bxs_regs
   import bxs_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int LEG_H_W = 10,
   parameter int LEG_W_W = 6,
   parameter int ENH_H_W = 15,
   parameter int ENH_W_W = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               busy,
   output logic               start,
   output logic [ENH_W_W-1:0] w_load,
   output logic [ENH_H_W-1:0] h_load,
   output logic [7:0]         minterm,
   output logic [DATA_W-9:0]  ctl_hi,
   output logic               store_off,
   output logic [DATA_W-2:0]  dmod_hi,
   output logic               ptr_hi_we,
   output logic               ptr_lo_we
);
   if (LEG_H_W + LEG_W_W != DATA_W) begin : g_bad_packed
      $error("packed size fields must fill the data word");
   end
   if (LEG_W_W >= ENH_W_W || LEG_H_W >= ENH_H_W || ENH_H_W >= DATA_W) begin : g_bad_enh
      $error("enhanced size fields must be wider than packed ones");
   end

   logic                 acc;
   logic [ENH_H_W-1:0]   vsize_q;
   logic [DATA_W-1:0]    ctl0_q;
   logic                 off_q;
   logic [DATA_W-2:0]    dmod_q;
   logic [LEG_W_W-1:0]   lw;
   logic [LEG_H_W-1:0]   lh;
   logic                 sel_packed;

   assign acc        = wr_en & ~busy;
   assign sel_packed = (wr_sel == SEL_PACKED);
   assign start      = acc & (sel_packed | (wr_sel == SEL_HSIZE));
   assign ptr_hi_we  = acc & (wr_sel == SEL_PTRHI);
   assign ptr_lo_we  = acc & (wr_sel == SEL_PTRLO);
   assign lw         = wr_data[LEG_W_W-1:0];
   assign lh         = wr_data[LEG_W_W +: LEG_H_W];

   // packed zero maps to one above the field range; enhanced zero wraps in the down-counter
   always_comb begin
      if (sel_packed) begin
         w_load = ENH_W_W'({~|lw, lw});
         h_load = ENH_H_W'({~|lh, lh});
      end else begin
         w_load = wr_data[ENH_W_W-1:0];
         h_load = vsize_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsize_q <= '0;
         ctl0_q  <= '0;
         off_q   <= 1'b0;
         dmod_q  <= '0;
      end else if (acc) begin
         case (wr_sel)
            SEL_VSIZE:  vsize_q <= wr_data[ENH_H_W-1:0];
            SEL_CTL0:   ctl0_q  <= wr_data;
            SEL_CTL0LO: ctl0_q[7:0] <= wr_data[7:0];
            SEL_CTL1:   off_q   <= wr_data[STORE_OFF_BIT];
            SEL_DMOD:   dmod_q  <= wr_data[DATA_W-1:1];
            default: ;
         endcase
      end
   end

   assign minterm   = ctl0_q[7:0];
   assign ctl_hi    = ctl0_q[DATA_W-1:8];
   assign store_off = off_q;
   assign dmod_hi   = dmod_q;

   // R9
   busy_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_en |=> $stable(ctl0_q) && $stable(off_q) && $stable(vsize_q) && $stable(dmod_q));
   // R6
   alias_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && wr_sel == SEL_CTL0LO |=> ctl0_q[DATA_W-1:8] == $past(ctl0_q[DATA_W-1:8]));
endmodule

// File: rtl/bxs_walker.sv
module bxs_walker #(
   parameter int ENH_H_W = 15,
   parameter int ENH_W_W = 11,
   parameter int ADDR_W  = 21,
   parameter int MOD_W   = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ENH_W_W-1:0] w_load,
   input  logic [ENH_H_W-1:0] h_load,
   input  logic               ptr_hi_we,
   input  logic               ptr_lo_we,
   input  logic [ADDR_W-17:0] ptr_hi_data,
   input  logic [14:0]        ptr_lo_data,
   input  logic [MOD_W-1:0]   dmod_hi,
   output logic               busy,
   output logic               done,
   output logic [ADDR_W-2:0]  waddr
);
   localparam int AW = ADDR_W - 1;

   if (AW <= MOD_W || ADDR_W <= 16) begin : g_bad_addr
      $error("address must be wider than the modulo");
   end

   logic               busy_q, done_q;
   logic [ENH_W_W-1:0] wcnt_q, wrow_q;
   logic [ENH_H_W-1:0] lcnt_q;
   logic [AW-1:0]      addr_q;
   logic               line_last, rect_last;
   logic [AW-1:0]      step;

   assign line_last = (wcnt_q == ENH_W_W'(1));
   assign rect_last = line_last && (lcnt_q == ENH_H_W'(1));
   assign step      = AW'(1) + (line_last ? {{(AW-MOD_W){dmod_hi[MOD_W-1]}}, dmod_hi} : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         wcnt_q <= '0;
         wrow_q <= '0;
         lcnt_q <= '0;
      end else begin
         done_q <= busy_q & rect_last;
         if (start) begin
            busy_q <= 1'b1;
            wcnt_q <= w_load;
            wrow_q <= w_load;
            lcnt_q <= h_load;
         end else if (busy_q) begin
            if (line_last) begin
               wcnt_q <= wrow_q;
               lcnt_q <= lcnt_q - 1'b1;
               if (rect_last) busy_q <= 1'b0;
            end else begin
               wcnt_q <= wcnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (busy_q) begin
         addr_q <= addr_q + step;
      end else if (ptr_hi_we) begin
         addr_q[AW-1:15] <= ptr_hi_data;
      end else if (ptr_lo_we) begin
         addr_q[14:0] <= ptr_lo_data;
      end
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign waddr = addr_q;

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy_q);
   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !line_last |=> addr_q == $past(addr_q) + AW'(1));
   // R2
   no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !start |=> !busy_q);
endmodule

// File: rtl/bxs_mix.sv
module bxs_mix #(
   parameter int DATA_W  = 16,
   parameter bit SOP_FORM = 1'b0
) (
   input  logic [7:0]        minterm,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] c,
   output logic [DATA_W-1:0] y
);
   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      if (SOP_FORM) begin : g_sop
         logic [7:0] term;
         for (genvar i = 0; i < 8; i++) begin : g_term
            assign term[i] = minterm[i]
               & (a[k] == i[2]) & (b[k] == i[1]) & (c[k] == i[0]);
         end
         assign y[k] = |term;
      end else begin : g_mux
         assign y[k] = minterm[{a[k], b[k], c[k]}];
      end
   end
endmodule

// File: rtl/blit_extent_seq.sv
module blit_extent_seq
   import bxs_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int LEG_H_W  = 10,
   parameter int LEG_W_W  = 6,
   parameter int ENH_H_W  = 15,
   parameter int ENH_W_W  = 11,
   parameter int ADDR_W   = 21,
   parameter bit SOP_FORM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_sel,
   input  logic [15:0]       wr_data,
   input  logic [15:0]       src_a,
   input  logic [15:0]       src_b,
   input  logic [15:0]       src_c,
   output logic              busy,
   output logic              done,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [20:0]       wr_addr,
   output logic [15:0]       dst_data,
   output logic [7:0]        ctl_hi
);
   if (DATA_W != 16 || ADDR_W != 21) begin : g_bad_port
      $error("port widths are fixed at 16 data and 21 address bits");
   end

   logic               start, store_off, ptr_hi_we, ptr_lo_we;
   logic [ENH_W_W-1:0] w_load;
   logic [ENH_H_W-1:0] h_load;
   logic [7:0]         minterm;
   logic [DATA_W-2:0]  dmod_hi;
   logic [ADDR_W-2:0]  waddr;

   bxs_regs #(
      .DATA_W(DATA_W), .LEG_H_W(LEG_H_W), .LEG_W_W(LEG_W_W),
      .ENH_H_W(ENH_H_W), .ENH_W_W(ENH_W_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .busy(busy), .start(start), .w_load(w_load), .h_load(h_load),
      .minterm(minterm), .ctl_hi(ctl_hi), .store_off(store_off), .dmod_hi(dmod_hi),
      .ptr_hi_we(ptr_hi_we), .ptr_lo_we(ptr_lo_we)
   );

   bxs_walker #(
      .ENH_H_W(ENH_H_W), .ENH_W_W(ENH_W_W), .ADDR_W(ADDR_W), .MOD_W(DATA_W-1)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .w_load(w_load), .h_load(h_load),
      .ptr_hi_we(ptr_hi_we), .ptr_lo_we(ptr_lo_we),
      .ptr_hi_data(wr_data[ADDR_W-17:0]), .ptr_lo_data(wr_data[15:1]),
      .dmod_hi(dmod_hi), .busy(busy), .done(done), .waddr(waddr)
   );

   bxs_mix #(.DATA_W(DATA_W), .SOP_FORM(SOP_FORM)) u_mix (
      .minterm(minterm), .a(src_a), .b(src_b), .c(src_c), .y(dst_data)
   );

   assign rd_stb  = busy;
   assign wr_stb  = busy & ~store_off;
   assign wr_addr = {waddr, 1'b0};

   // R5
   store_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> rd_stb);
   // R5
   store_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_off |-> !wr_stb);
   // R10
   idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_stb && !wr_stb);
endmodule

// File: tb/blit_extent_seq_tb.sv
module blit_extent_seq_tb;
   localparam logic [3:0] S_PK = 4'd0, S_VS = 4'd1, S_HS = 4'd2, S_C0 = 4'd3,
                          S_C0L = 4'd4, S_C1 = 4'd5, S_PH = 4'd6, S_PL = 4'd7, S_MD = 4'd8;

   typedef struct packed {
      logic        pk;
      logic [15:0] h;
      logic [15:0] w;
      logic [7:0]  mt;
      logic        off;
      logic [15:0] md;
      logic [20:0] ptr;
   } vec_t;

   localparam vec_t VT [7] = '{
      '{1'b1, 16'd3, 16'd4, 8'hF0, 1'b0, 16'h0004, 21'h001000},
      '{1'b0, 16'd5, 16'd2, 8'hCC, 1'b0, 16'hFFFE, 21'h012340},
      '{1'b0, 16'd2, 16'd7, 8'hAA, 1'b1, 16'h0000, 21'h000200},
      '{1'b1, 16'd1, 16'd0, 8'h96, 1'b0, 16'h0008, 21'h003000},
      '{1'b1, 16'd0, 16'd1, 8'h80, 1'b0, 16'h0000, 21'h000000},
      '{1'b0, 16'd1, 16'd0, 8'hFE, 1'b0, 16'h0000, 21'h100000},
      '{1'b0, 16'd0, 16'd1, 8'h17, 1'b0, 16'h0002, 21'h000010}
   };

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [15:0] wr_data = '0, src_a = '0, src_b = '0, src_c = '0;
   logic busy, done, rd_stb, wr_stb;
   logic [20:0] wr_addr;
   logic [15:0] dst_data;
   logic [7:0]  ctl_hi;

   int n_chk = 0, n_bad = 0;
   int c_rd = 0, c_wr = 0, c_busy = 0, c_done = 0, c_baddone = 0;
   logic prev_busy = 1'b0;
   logic [20:0] f_addr, l_addr;
   logic [15:0] f_data;

   always #10 clk = ~clk;

   blit_extent_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .src_a(src_a), .src_b(src_b), .src_c(src_c), .busy(busy), .done(done),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_addr(wr_addr), .dst_data(dst_data),
      .ctl_hi(ctl_hi)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_stb) c_rd++;
         if (wr_stb) begin c_wr++; l_addr = wr_addr; end
         if (busy) c_busy++;
         if (done) begin
            c_done++;
            if (busy || !prev_busy) c_baddone++;
         end
         if (busy && !prev_busy) begin f_addr = wr_addr; f_data = dst_data; end
         prev_busy = busy;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] s, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      int g = 0;
      while (busy && g < 40000) begin @(negedge clk); g++; end
      chk(g < 40000, "R8 blit ends", g, 0);
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [15:0] fn3(input logic [7:0] mt, input logic [15:0] a,
                                       input logic [15:0] b, input logic [15:0] c);
      logic [15:0] r = '0;
      for (int i = 0; i < 8; i++)
         if (mt[i]) r |= (i[2] ? a : ~a) & (i[1] ? b : ~b) & (i[0] ? c : ~c);
      return r;
   endfunction

   int b_rd, b_wr, b_busy, b_done, b_bd;
   task automatic snap();
      b_rd = c_rd; b_wr = c_wr; b_busy = c_busy; b_done = c_done; b_bd = c_baddone;
   endtask

   initial begin
      vec_t v;
      int ew, eh, n, md;
      logic [20:0] ea;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!busy && !done && !rd_stb && !wr_stb, "R10 reset outputs", {busy, done, rd_stb, wr_stb}, 0);
      chk(ctl_hi == 8'h00, "R10 reset ctl_hi", ctl_hi, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 7; i++) begin
         v = VT[i];
         src_a = 16'hF00F ^ 16'(i * 16'h1111);
         src_b = 16'hCCCC ^ 16'(i * 16'h0707);
         src_c = 16'hAAAA + 16'(i * 16'h0123);
         wr(S_C0, {8'h5A, v.mt});
         wr(S_C1, v.off ? 16'h0080 : 16'h0000);
         wr(S_PH, {11'd0, v.ptr[20:16]});
         wr(S_PL, v.ptr[15:0]);
         wr(S_MD, v.md);
         if (v.pk) begin
            ew = (v.w[5:0] == 0) ? 64 : int'(v.w[5:0]);
            eh = (v.h[9:0] == 0) ? 1024 : int'(v.h[9:0]);
         end else begin
            ew = (v.w[10:0] == 0) ? 2048 : int'(v.w[10:0]);
            eh = (v.h[14:0] == 0) ? 32768 : int'(v.h[14:0]);
         end
         n = ew * eh;
         md = int'(signed'(v.md));
         snap();
         if (v.pk) wr(S_PK, {v.h[9:0], v.w[5:0]});
         else begin wr(S_VS, v.h); wr(S_HS, v.w); end
         // R2 busy already up one edge after the starting write
         chk(busy, "R2 busy after start", busy, 1);
         wait_idle();
         // R1 R3 word counts
         chk(c_rd - b_rd == n, "R1/R3 read count", c_rd - b_rd, n);
         // R5 store count with and without suppression
         chk(c_wr - b_wr == (v.off ? 0 : n), "R5 write count", c_wr - b_wr, v.off ? 0 : n);
         // R8 busy length and done pulse
         chk(c_busy - b_busy == n, "R8 busy cycles", c_busy - b_busy, n);
         chk(c_done - b_done == 1 && c_baddone == b_bd, "R8 done pulse", c_done - b_done, 1);
         // R7 first address
         chk(f_addr == v.ptr, "R7 first address", f_addr, v.ptr);
         // R4 function on first word
         chk(f_data == fn3(v.mt, src_a, src_b, src_c), "R4 minterm data", f_data,
             fn3(v.mt, src_a, src_b, src_c));
         if (!v.off) begin
            ea = 21'(int'(v.ptr) + 2 * (n - 1) + (eh - 1) * md);
            chk(l_addr == ea, "R7 last address", l_addr, ea);
         end
      end

      // R2 vertical write alone starts nothing
      wr(S_C1, 16'h0000);
      wr(S_MD, 16'h0000);
      wr(S_PH, 16'h0000);
      wr(S_PL, 16'h0400);
      snap();
      wr(S_VS, 16'd2);
      repeat (3) @(negedge clk);
      chk(c_busy == b_busy && !busy, "R2 vsize no start", c_busy - b_busy, 0);
      wr(S_HS, 16'd3);
      wait_idle();
      chk(c_wr - b_wr == 6, "R2 hsize starts with stored height", c_wr - b_wr, 6);

      // R9 writes while busy ignored
      wr(S_PL, 16'h0800);
      wr(S_VS, 16'd4);
      snap();
      wr(S_HS, 16'd4);
      wr(S_HS, 16'd1);
      wr(S_PL, 16'h0040);
      wr(S_C1, 16'h0080);
      wr(S_C0, 16'h11FF);
      wait_idle();
      chk(c_wr - b_wr == 16, "R9 size write ignored", c_wr - b_wr, 16);
      chk(l_addr == 21'h00081E, "R9 pointer write ignored", l_addr, 21'h00081E);
      chk(ctl_hi == 8'h5A, "R9 control write ignored", ctl_hi, 8'h5A);

      // R5 R7 suppressed stores still advance pointer
      wr(S_PL, 16'h0800);
      wr(S_MD, 16'h0004);
      wr(S_C1, 16'h0080);
      wr(S_VS, 16'd2);
      snap();
      wr(S_HS, 16'd3);
      wait_idle();
      chk(c_rd - b_rd == 6 && c_wr == b_wr, "R5 reads without stores", c_wr - b_wr, 0);
      wr(S_C1, 16'h0000);
      wr(S_VS, 16'd1);
      wr(S_HS, 16'd1);
      wait_idle();
      chk(f_addr == 21'h000814, "R7 pointer carried after suppressed blit", f_addr, 21'h000814);

      // R6 low-byte alias
      wr(S_C0, 16'hA5F0);
      chk(ctl_hi == 8'hA5, "R6 full control write", ctl_hi, 8'hA5);
      wr(S_C0L, 16'h3CCC);
      chk(ctl_hi == 8'hA5, "R6 alias keeps upper byte", ctl_hi, 8'hA5);
      src_a = 16'h1234; src_b = 16'hBEEF; src_c = 16'h0F0F;
      wr(S_HS, 16'd1);
      wait_idle();
      chk(f_data == 16'hBEEF, "R6 alias sets function", f_data, 16'hBEEF);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule